// File: doc/BRIEF.md
# CPU and Bus Clock Enable Divider

This block turns one of four source clock-enable streams into a CPU clock enable and a bus clock enable. All of its logic runs on a single fast reference clock. Each source (main, sub, on-chip oscillator, PLL) arrives as a single-cycle enable pulse that is already synchronous to that clock. A two-bit select chooses the active source. The block counts pulses of that source and raises the CPU enable once every N source pulses, where N comes from a five-bit divide field. When the sub source is selected, the divide field is bypassed and every sub pulse becomes a CPU pulse.

The bus enable runs in one of two modes. In single-speed mode it copies the CPU enable. In double-speed mode it takes every second CPU enable. The divide field is software-writable and is loaded with divide-by-8 at reset. A request to enter a stop or low-power state also forces it back to divide-by-8, except while the on-chip oscillator is the active source. Whenever the select or the divide field changes, the pulse counter restarts, so a change never produces a shortened CPU period.

Top module: `cpu_bus_clkdiv`

## Requirements
- R1: `cpu_en` is high for one cycle only when the source chosen by `src_sel` pulsed in the previous cycle. The codes are 0 = main, 1 = sub, 2 = on-chip oscillator, 3 = PLL.
- R2: With main, oscillator or PLL selected, `cpu_en` fires once every k source pulses, where k is the divide field value (1..31), and 0 means 16. With sub selected, every sub pulse produces a `cpu_en` and the divide field is ignored.
- R3: At reset, `div_field` reads 8, `cpu_en` and `bus_en` are low, and double-speed phase tracking starts cleared.
- R4: With `double_speed` low, `bus_en` equals `cpu_en` on every cycle. `bus_en` is never high without `cpu_en`.
- R5: With `double_speed` high, `bus_en` accompanies every second `cpu_en` pulse, alternating.
- R6: A cycle with `lp_enter` high sets `div_field` to 8 on the next cycle, unless `src_sel` is 2 (on-chip oscillator). This takes priority over a write in the same cycle. When the oscillator is selected, `lp_enter` leaves the field unchanged.
- R7: In the cycle after `src_sel` or `div_field` changes, the counter restarts and `cpu_en` stays low. The next pulse comes after k full source pulses.
- R8: A cycle with `div_wr` high loads `div_val` into the divide field, and `div_field` shows the new value on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_main_en | input | 1 | Main source enable pulse |
| src_sub_en | input | 1 | Sub source enable pulse |
| src_osc_en | input | 1 | On-chip oscillator enable pulse |
| src_pll_en | input | 1 | PLL source enable pulse |
| src_sel | input | 2 | Source select (0 main, 1 sub, 2 osc, 3 PLL) |
| div_wr | input | 1 | Divide field write strobe |
| div_val | input | 5 | Divide value to write (0 = divide by 16) |
| double_speed | input | 1 | 1 = bus enable at half the CPU enable rate |
| lp_enter | input | 1 | Stop / low-power entry request |
| cpu_en | output | 1 | CPU clock enable pulse |
| bus_en | output | 1 | Bus clock enable pulse |
| div_field | output | 5 | Current divide field |

## Verification
The assertions assume that the source enables and all control inputs are synchronous to `clk`, and that `src_sel` is held at 0 while reset is active. The alternation check assumes that `double_speed` changes only between measurement windows. The bench changes every input 2 ns after a rising edge and holds `src_sel` at zero through reset. It also gives each new configuration a settling window of at least two full output periods before any interval is measured, so that restart pulses and mode switches never fall inside a scored interval.

// File: rtl/clkdiv_pkg.sv
// Shared types and constants for the CPU/bus clock enable divider.
// Assumes a two-bit source select. The enum values are the select codes.
package clkdiv_pkg;
    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_SUB  = 2'd1,
        SRC_OSC  = 2'd2,
        SRC_PLL  = 2'd3
    } src_sel_e;

    localparam int unsigned DIV_RESET = 8;
endpackage

// File: rtl/clkdiv_src_mux.sv
// Selects one source enable pulse out of NSRC by index.
// Assumes every source enable is a single-cycle pulse synchronous to clk.
module clkdiv_src_mux #(
    parameter int NSRC  = 4,
    parameter int SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  src_en,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    // Pick the pulse of the selected source.
    always_comb begin
        pulse = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) pulse = src_en[i];
        end
    end
endmodule

// File: rtl/clkdiv_field_reg.sv
// Holds the divide field. Loads it from writes and forces it to the
// default value on a low-power entry request, unless the exempt source is
// selected. Assumes lp_enter and div_wr are single-cycle synchronous strobes.
module clkdiv_field_reg #(
    parameter int                DIV_W     = 5,
    parameter int                SEL_W     = 2,
    parameter logic [DIV_W-1:0]  RESET_VAL = DIV_W'(8),
    parameter logic [SEL_W-1:0]  EXEMPT    = SEL_W'(2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             lp_enter,
    input  logic [SEL_W-1:0] src_sel,
    output logic [DIV_W-1:0] field
);
    logic force_dflt;

    // A low-power request forces the default unless the exempt source runs.
    always_comb force_dflt = lp_enter && (src_sel != EXEMPT);

    // Field register: forced default has priority over a write.
    always_ff @(posedge clk) begin
        if (!rst_n)          field <= RESET_VAL;
        else if (force_dflt) field <= RESET_VAL;
        else if (div_wr)     field <= div_val;
    end
endmodule

// File: rtl/clkdiv_counter.sv
// Counts selected source pulses and emits one CPU enable every 'ratio'
// pulses. The bypass source skips the division. Restarts the count whenever
// the select or the field changes. Assumes field 0 means 2**(DIV_W-1).
module clkdiv_counter #(
    parameter int                DIV_W     = 5,
    parameter int                SEL_W     = 2,
    parameter logic [DIV_W-1:0]  RESET_VAL = DIV_W'(8),
    parameter logic [SEL_W-1:0]  BYPASS    = SEL_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] field,
    output logic             cpu_en
);
    localparam logic [DIV_W-1:0] ZERO_TERM = DIV_W'((1 << (DIV_W - 1)) - 1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] term;
    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] field_q;
    logic             restart;
    logic             bypass;

    // Terminal count: last count value before the enable fires.
    always_comb term = (field == '0) ? ZERO_TERM : field - DIV_W'(1);

    // Detect a change of source or divide value since the last cycle.
    always_comb restart = (src_sel != sel_q) || (field != field_q);

    // The bypass source passes pulses straight through.
    always_comb bypass = (src_sel == BYPASS);

    // History of select and field for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            field_q <= RESET_VAL;
        end else begin
            sel_q   <= src_sel;
            field_q <= field;
        end
    end

    // Pulse counter and registered CPU enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            cpu_en <= 1'b0;
        end else if (restart) begin
            cnt    <= '0;
            cpu_en <= 1'b0;
        end else if (pulse) begin
            if (bypass || cnt == term) begin
                cnt    <= '0;
                cpu_en <= 1'b1;
            end else begin
                cnt    <= cnt + DIV_W'(1);
                cpu_en <= 1'b0;
            end
        end else begin
            cpu_en <= 1'b0;
        end
    end
endmodule

// File: rtl/clkdiv_bus_gen.sv
// Derives the bus enable from the CPU enable: a copy in single-speed mode,
// every second pulse in double-speed mode. Assumes cpu_en is a one-cycle pulse.
module clkdiv_bus_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_en,
    input  logic double_speed,
    output logic bus_en
);
    logic skip;

    // Phase bit: set after a pulse that produced a bus enable in double mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !double_speed) skip <= 1'b0;
        else if (cpu_en)             skip <= ~skip;
    end

    // Gate the CPU enable by the phase when double speed is on.
    always_comb bus_en = cpu_en && !(double_speed && skip);
endmodule

// File: rtl/cpu_bus_clkdiv.sv
// Top level of the CPU/bus clock enable divider. Wires the source mux, the
// divide field register, the pulse counter and the bus enable generator.
// Assumes all inputs are synchronous to clk.
module cpu_bus_clkdiv #(
    parameter int DIV_W = 5,
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_main_en,
    input  logic             src_sub_en,
    input  logic             src_osc_en,
    input  logic             src_pll_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             double_speed,
    input  logic             lp_enter,
    output logic             cpu_en,
    output logic             bus_en,
    output logic [DIV_W-1:0] div_field
);
    import clkdiv_pkg::*;

    localparam logic [DIV_W-1:0] RESET_VAL = DIV_W'(DIV_RESET);
    localparam logic [SEL_W-1:0] OSC_CODE  = SEL_W'(SRC_OSC);
    localparam logic [SEL_W-1:0] SUB_CODE  = SEL_W'(SRC_SUB);

    logic [NSRC-1:0] src_vec;
    logic            sel_pulse;

    // Order the source enables by their select codes.
    always_comb begin
        src_vec = '0;
        src_vec[SRC_MAIN] = src_main_en;
        src_vec[SRC_SUB]  = src_sub_en;
        src_vec[SRC_OSC]  = src_osc_en;
        src_vec[SRC_PLL]  = src_pll_en;
    end

    clkdiv_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
        .src_en (src_vec),
        .sel    (src_sel),
        .pulse  (sel_pulse)
    );

    clkdiv_field_reg #(
        .DIV_W(DIV_W), .SEL_W(SEL_W), .RESET_VAL(RESET_VAL), .EXEMPT(OSC_CODE)
    ) u_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_val  (div_val),
        .lp_enter (lp_enter),
        .src_sel  (src_sel),
        .field    (div_field)
    );

    clkdiv_counter #(
        .DIV_W(DIV_W), .SEL_W(SEL_W), .RESET_VAL(RESET_VAL), .BYPASS(SUB_CODE)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (sel_pulse),
        .src_sel (src_sel),
        .field   (div_field),
        .cpu_en  (cpu_en)
    );

    clkdiv_bus_gen u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_en       (cpu_en),
        .double_speed (double_speed),
        .bus_en       (bus_en)
    );
endmodule

// File: rtl/cpu_bus_clkdiv_chk.sv
// Assertion checker for cpu_bus_clkdiv, bound to every instance of the top.
module cpu_bus_clkdiv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       src_main_en,
    input logic       src_sub_en,
    input logic       src_osc_en,
    input logic       src_pll_en,
    input logic [1:0] src_sel,
    input logic       div_wr,
    input logic [4:0] div_val,
    input logic       double_speed,
    input logic       lp_enter,
    input logic       cpu_en,
    input logic       bus_en,
    input logic [4:0] div_field
);
    logic chosen;
    logic dbl_seen;
    logic dbl_last;

    // Enable of the currently selected source.
    always_comb begin
        case (src_sel)
            2'd0:    chosen = src_main_en;
            2'd1:    chosen = src_sub_en;
            2'd2:    chosen = src_osc_en;
            default: chosen = src_pll_en;
        endcase
    end

    // Track the bus flag of the last CPU pulse in double-speed mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !double_speed) begin
            dbl_seen <= 1'b0;
            dbl_last <= 1'b0;
        end else if (cpu_en) begin
            dbl_seen <= 1'b1;
            dbl_last <= bus_en;
        end
    end

    AST_CPU_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> $past(chosen)); // R1
    AST_RESET_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (div_field == 5'd8 && !cpu_en && !bus_en)); // R3
    AST_BUS_NEEDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> cpu_en); // R4
    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        !double_speed |-> (bus_en == cpu_en)); // R4
    AST_DOUBLE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (double_speed && cpu_en && dbl_seen) |-> (bus_en != dbl_last)); // R5
    AST_LP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_enter && src_sel != 2'd2) |=> (div_field == 5'd8)); // R6
    AST_LP_OSC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_enter && src_sel == 2'd2 && !div_wr) |=> $stable(div_field)); // R6
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (div_field != $past(div_field) || src_sel != $past(src_sel)) |=> !cpu_en); // R7
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && !(lp_enter && src_sel != 2'd2)) |=> (div_field == $past(div_val))); // R8
endmodule

bind cpu_bus_clkdiv cpu_bus_clkdiv_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_main_en  (src_main_en),
    .src_sub_en   (src_sub_en),
    .src_osc_en   (src_osc_en),
    .src_pll_en   (src_pll_en),
    .src_sel      (src_sel),
    .div_wr       (div_wr),
    .div_val      (div_val),
    .double_speed (double_speed),
    .lp_enter     (lp_enter),
    .cpu_en       (cpu_en),
    .bus_en       (bus_en),
    .div_field    (div_field)
);

// File: tb/cpu_bus_clkdiv_test.sv
// Scoreboard bench: a driver task queues expected pulse intervals and bus
// behaviour, and a monitor measures cpu_en intervals and compares them.
module cpu_bus_clkdiv_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_main_en = 1'b0, src_sub_en = 1'b0, src_osc_en = 1'b0, src_pll_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       div_wr = 1'b0;
    logic [4:0] div_val = 5'd0;
    logic       double_speed = 1'b0;
    logic       lp_enter = 1'b0;
    logic       cpu_en, bus_en;
    logic [4:0] div_field;

    typedef struct { int period; int bmode; string req; } exp_t; // bmode 1 every, 2 alternate
    exp_t exp_q[$];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit armed = 0;
    bit have_last = 0;
    int last_cyc = 0;
    bit last_bus = 0;

    cpu_bus_clkdiv uut (
        .clk(clk), .rst_n(rst_n),
        .src_main_en(src_main_en), .src_sub_en(src_sub_en),
        .src_osc_en(src_osc_en), .src_pll_en(src_pll_en),
        .src_sel(src_sel), .div_wr(div_wr), .div_val(div_val),
        .double_speed(double_speed), .lp_enter(lp_enter),
        .cpu_en(cpu_en), .bus_en(bus_en), .div_field(div_field)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Source patterns: main and osc every cycle, PLL every 2nd, sub every 3rd.
    always @(posedge clk) begin
        #2;
        src_main_en = 1'b1;
        src_osc_en  = 1'b1;
        src_pll_en  = (cyc % 2) == 0;
        src_sub_en  = (cyc % 3) == 0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: measure intervals between cpu_en pulses and score them.
    always @(negedge clk) begin
        if (armed && cpu_en) begin
            if (have_last && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc - last_cyc == e.period, e.req, "cpu_en interval",
                      cyc - last_cyc, e.period);
                if (e.bmode == 1)
                    check(bus_en == 1'b1, e.req, "bus_en with cpu_en", int'(bus_en), 1);
                else
                    check(bus_en != last_bus, e.req, "bus_en alternation",
                          int'(bus_en), int'(!last_bus));
            end
            have_last = 1;
            last_cyc  = cyc;
            last_bus  = bus_en;
        end
    end

    // Driver: settle, then queue n expected intervals and wait for them.
    task automatic run_case(input int period, input int bmode, input int n, input string req);
        repeat (70) @(posedge clk);
        #2;
        have_last = 0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.period = period; e.bmode = bmode; e.req = req;
            exp_q.push_back(e);
        end
        armed = 1;
        while (exp_q.size() > 0) @(posedge clk);
        #2;
        armed = 0;
    endtask

    task automatic write_div(input logic [4:0] v);
        div_wr = 1'b1; div_val = v;
        @(posedge clk); #2;
        div_wr = 1'b0;
        check(div_field == v, "R8", "div_field after write", int'(div_field), int'(v));
    endtask

    task automatic pulse_lp(input bit with_wr, input logic [4:0] v);
        lp_enter = 1'b1; div_wr = with_wr; div_val = v;
        @(posedge clk); #2;
        lp_enter = 1'b0; div_wr = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(cpu_en == 1'b0 && bus_en == 1'b0, "R3", "enables in reset",
              int'({cpu_en, bus_en}), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(div_field == 5'd8, "R3", "div_field after reset", int'(div_field), 8);

        // R3 R2 R4: default divide by 8 on main, single speed.
        run_case(8, 1, 4, "R3");
        // R7: write 3 right after a pulse; first new pulse 6 negedges later.
        @(negedge clk);
        while (!cpu_en) @(negedge clk);
        @(posedge clk); #2;
        div_wr = 1'b1; div_val = 5'd3;
        @(negedge clk); n = 1;
        @(posedge clk); #2; div_wr = 1'b0;
        do begin @(negedge clk); n++; end while (!cpu_en && n < 100);
        check(n == 6, "R7", "restart delay", n, 6);
        @(posedge clk); #2;
        // R2 various divide values on main.
        write_div(5'd5);  run_case(5, 1, 4, "R2");
        write_div(5'd0);  run_case(16, 1, 3, "R2");
        write_div(5'd1);  run_case(1, 1, 5, "R2");
        // R1: PLL pulses every 2nd cycle, divide 3 gives 6.
        write_div(5'd3);
        src_sel = 2'd3;   run_case(6, 1, 4, "R1");
        // R2: sub bypasses the divide field, period 3.
        src_sel = 2'd1;   run_case(3, 1, 4, "R2");
        // R5: double speed alternates.
        double_speed = 1'b1; run_case(3, 2, 6, "R5");
        src_sel = 2'd0; write_div(5'd4); run_case(4, 2, 6, "R5");
        double_speed = 1'b0; run_case(4, 1, 3, "R4");
        // R6: low-power entry on main forces 8.
        pulse_lp(1'b0, 5'd0);
        check(div_field == 5'd8, "R6", "lp force on main", int'(div_field), 8);
        write_div(5'd6);
        pulse_lp(1'b1, 5'd2);
        check(div_field == 5'd8, "R6", "lp beats write", int'(div_field), 8);
        // R6 R1: oscillator selected keeps the field.
        src_sel = 2'd2; write_div(5'd6);
        pulse_lp(1'b0, 5'd0);
        check(div_field == 5'd6, "R6", "lp on osc keeps field", int'(div_field), 6);
        run_case(6, 1, 3, "R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule